// File: doc/BRIEF.md
# Aliased Sub-Register File

This block holds sixteen 64-bit general-purpose registers. Each register can be read or written through a narrower view that overlaps its low-order bits: all 64 bits, the low 32 bits, the low 16 bits or the low byte. The first four registers also offer a fifth view, which is the byte in bits 15:8. A datapath uses it the same way a general-register file is used in a machine whose instructions operate on operands of several sizes. The datapath gives a register index and a view code on each port. The file does the slicing, the extension and the merging.

The read port is combinational. It returns the selected view placed at the bottom of the 64-bit result. The upper bits are filled with zeros, or with copies of the view's top bit when sign extension is requested. A move that widens a byte or word into a larger destination is therefore a narrow read with zero extension followed by a wide write. The write port commits on the rising edge. A 32-bit write clears the upper half of the register. A 16-bit or 8-bit write changes only its own slice. A request for the bits 15:8 view on a register that lacks it, or any undefined view code, is flagged as illegal. Such a write has no effect, and such a read returns zero.

Top module: `subreg_file`

## Requirements
- R1: A synchronous active-high reset clears every register, so every view of every register reads zero after it.
- R2: With view code 0 (64 bits), a write stores the whole input word and a read returns the whole register.
- R3: A write with view code 1 (32 bits) stores bits 31:0 of the input in bits 31:0 and clears bits 63:32.
- R4: A write with view code 2 (16 bits) stores bits 15:0 of the input in bits 15:0 and leaves bits 63:16 unchanged.
- R5: A write with view code 3 (low byte) stores bits 7:0 of the input in bits 7:0 and leaves bits 63:8 unchanged.
- R6: On registers 0 to 3, view code 4 reads bits 15:8 of the register as a byte. A write with view code 4 puts input bits 7:0 into register bits 15:8 and leaves all other bits unchanged.
- R7: View code 4 on register 4 or above, and view codes 5 to 7 on any register, are illegal. An illegal read raises rd_illegal and returns zero. An illegal write raises wr_illegal and changes no register.
- R8: With rd_sext low, a read of view 1, 2, 3 or 4 returns the view in the low bits and zeros above it.
- R9: With rd_sext high, a read of view 1, 2, 3 or 4 fills every bit above the view with the view's most significant bit. Sign extension has no effect on view 0.
- R10: A read of the register being written in the same cycle returns the value from before the write.
- R11: A write changes only the addressed register. Register 15 behaves like any other register.
- R12: With wr_en low, no register changes and wr_illegal stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 4 | Register index for the read port |
| rd_view | input | 3 | Read view code (0 = 64, 1 = 32, 2 = 16, 3 = low byte, 4 = bits 15:8) |
| rd_sext | input | 1 | 1 = sign-extend the read view, 0 = zero-extend it |
| rd_data | output | 64 | Extended read result |
| rd_illegal | output | 1 | The read view is not available for rd_idx |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Register index for the write port |
| wr_view | input | 3 | Write view code, same encoding as rd_view |
| wr_data | input | 64 | Write data; the view takes its low bits |
| wr_illegal | output | 1 | A write was requested with a view not available for wr_idx |

## Verification
The bench builds the file with its default parameters: sixteen registers of 64 bits, four of which have the bits 15:8 view. With these values the boundary between index 3 and index 4 for that view can be reached, as can the last register, index 15. Random view codes cover all eight encodings, which includes the three undefined codes. Random write and read indices collide often, so reads that coincide with a write to the same register happen many times.

// File: rtl/subreg_pkg.sv
`timescale 1ns/1ps
package subreg_pkg;

  localparam int VIEW_W = 3;

  typedef enum logic [VIEW_W-1:0] {
    VIEW_QUAD   = 3'd0,
    VIEW_DWORD  = 3'd1,
    VIEW_WORD   = 3'd2,
    VIEW_BYTE   = 3'd3,
    VIEW_HIBYTE = 3'd4
  } view_e;

  // A view is usable when its code is defined and, for the bits 15:8 view,
  // when the register carries that view.
  function automatic logic view_legal(input logic [VIEW_W-1:0] view,
                                      input logic hi_ok);
    logic defined;
    defined = (view <= VIEW_HIBYTE);
    return defined && ((view != VIEW_HIBYTE) || hi_ok);
  endfunction

endpackage

// File: rtl/subreg_storage.sv
`timescale 1ns/1ps
module subreg_storage #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 64,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        regs[i] <= '0;
      end
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  // Both ports read asynchronously: port a serves the datapath, port b feeds
  // the merge of a partial write.
  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/subreg_read_view.sv
`timescale 1ns/1ps
module subreg_read_view
  import subreg_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] word,
  input  logic [VIEW_W-1:0] view,
  input  logic              sext,
  input  logic              legal,
  output logic [DATA_W-1:0] data
);

  localparam int HALF_W = DATA_W / 2;
  localparam int QTR_W  = DATA_W / 4;
  localparam int BYTE_W = 8;
  localparam logic [DATA_W-1:0] MASK_HALF = DATA_W'({HALF_W{1'b1}});
  localparam logic [DATA_W-1:0] MASK_QTR  = DATA_W'({QTR_W{1'b1}});
  localparam logic [DATA_W-1:0] MASK_BYTE = DATA_W'({BYTE_W{1'b1}});

  logic [DATA_W-1:0] field;
  logic [DATA_W-1:0] keep;
  logic              msb;

  always_comb begin
    field = '0;
    keep  = '1;
    msb   = 1'b0;
    unique case (view)
      VIEW_QUAD: begin
        field = word;
      end
      VIEW_DWORD: begin
        field = DATA_W'(word[HALF_W-1:0]);
        keep  = MASK_HALF;
        msb   = word[HALF_W-1];
      end
      VIEW_WORD: begin
        field = DATA_W'(word[QTR_W-1:0]);
        keep  = MASK_QTR;
        msb   = word[QTR_W-1];
      end
      VIEW_BYTE: begin
        field = DATA_W'(word[BYTE_W-1:0]);
        keep  = MASK_BYTE;
        msb   = word[BYTE_W-1];
      end
      VIEW_HIBYTE: begin
        field = DATA_W'(word[2*BYTE_W-1:BYTE_W]);
        keep  = MASK_BYTE;
        msb   = word[2*BYTE_W-1];
      end
      default: begin
        field = '0;
      end
    endcase
  end

  always_comb begin
    if (!legal) begin
      data = '0;
    end else if (sext && msb) begin
      data = field | ~keep;
    end else begin
      data = field;
    end
  end

endmodule

// File: rtl/subreg_write_merge.sv
`timescale 1ns/1ps
module subreg_write_merge
  import subreg_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [VIEW_W-1:0] view,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] merged
);

  localparam int HALF_W = DATA_W / 2;
  localparam int QTR_W  = DATA_W / 4;
  localparam int BYTE_W = 8;

  always_comb begin
    unique case (view)
      VIEW_QUAD:   merged = wdata;
      VIEW_DWORD:  merged = DATA_W'(wdata[HALF_W-1:0]);
      VIEW_WORD:   merged = {old_word[DATA_W-1:QTR_W], wdata[QTR_W-1:0]};
      VIEW_BYTE:   merged = {old_word[DATA_W-1:BYTE_W], wdata[BYTE_W-1:0]};
      VIEW_HIBYTE: merged = {old_word[DATA_W-1:2*BYTE_W], wdata[BYTE_W-1:0],
                             old_word[BYTE_W-1:0]};
      default:     merged = old_word;
    endcase
  end

endmodule

// File: rtl/subreg_file.sv
`timescale 1ns/1ps
module subreg_file
  import subreg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 64,
  parameter int NUM_HI   = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [VIEW_W-1:0] rd_view,
  input  logic              rd_sext,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_illegal,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VIEW_W-1:0] wr_view,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_illegal
);

  logic              rd_legal;
  logic              wr_legal;
  logic              wr_commit;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] wr_old;
  logic [DATA_W-1:0] wr_merged;

  assign rd_legal   = view_legal(rd_view, rd_idx < IDX_W'(NUM_HI));
  assign wr_legal   = view_legal(wr_view, wr_idx < IDX_W'(NUM_HI));
  assign rd_illegal = !rd_legal;
  assign wr_illegal = wr_en && !wr_legal;
  assign wr_commit  = wr_en && wr_legal;

  subreg_storage #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_commit),
    .waddr   (wr_idx),
    .wdata   (wr_merged),
    .raddr_a (rd_idx),
    .rdata_a (rd_word),
    .raddr_b (wr_idx),
    .rdata_b (wr_old)
  );

  subreg_write_merge #(
    .DATA_W (DATA_W)
  ) u_merge (
    .old_word (wr_old),
    .view     (wr_view),
    .wdata    (wr_data),
    .merged   (wr_merged)
  );

  subreg_read_view #(
    .DATA_W (DATA_W)
  ) u_rview (
    .word  (rd_word),
    .view  (rd_view),
    .sext  (rd_sext),
    .legal (rd_legal),
    .data  (rd_data)
  );

endmodule

// File: rtl/subreg_file_chk.sv
`timescale 1ns/1ps
module subreg_file_chk
  import subreg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 64,
  parameter int NUM_HI   = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [VIEW_W-1:0] rd_view,
  input logic              rd_sext,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_illegal,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [VIEW_W-1:0] wr_view,
  input logic              wr_illegal
);

  // R1: the first cycle out of reset sees only zeros
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_data == '0));

  // R3: a 32-bit write leaves the upper half clear when read back as 64 bits
  p_dword_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_view == VIEW_DWORD) |=>
      (rd_idx != $past(wr_idx) || rd_view != VIEW_QUAD ||
       rd_data[DATA_W-1:DATA_W/2] == '0));

  // R7: an illegal read view gives zero data
  p_illegal_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_view == VIEW_HIBYTE && rd_idx >= IDX_W'(NUM_HI)) |->
      (rd_illegal && rd_data == '0));

  // R7: an illegal write leaves a steady read unchanged
  p_illegal_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_illegal) |=>
      (rd_idx != $past(rd_idx) || rd_view != $past(rd_view) ||
       rd_sext != $past(rd_sext) || rd_data == $past(rd_data)));

  // R12: no write request leaves a steady read unchanged
  p_idle_stable_r12: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=>
      (rd_idx != $past(rd_idx) || rd_view != $past(rd_view) ||
       rd_sext != $past(rd_sext) || rd_data == $past(rd_data)));

  // R12: the write flag never rises without a request
  p_idle_noflag_r12: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |-> !wr_illegal);

  // R8: a zero-extended low byte has nothing above bit 7
  p_zext_byte_r8: assert property (@(posedge clk) disable iff (rst)
    (!rd_sext && rd_view == VIEW_BYTE) |-> (rd_data[DATA_W-1:8] == '0));

  // R9: a sign-extended low byte repeats bit 7 upward
  p_sext_byte_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_sext && rd_view == VIEW_BYTE) |->
      (rd_data[DATA_W-1:8] == {(DATA_W-8){rd_data[7]}}));

endmodule

bind subreg_file subreg_file_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .NUM_HI   (NUM_HI)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_idx     (rd_idx),
  .rd_view    (rd_view),
  .rd_sext    (rd_sext),
  .rd_data    (rd_data),
  .rd_illegal (rd_illegal),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_view    (wr_view),
  .wr_illegal (wr_illegal)
);

// File: tb/tb_subreg_file.sv
`timescale 1ns/1ps
module tb_subreg_file;

  localparam int NUM_REGS = 16;
  localparam int DATA_W   = 64;
  localparam int NUM_HI   = 4;
  localparam int IDX_W    = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic [IDX_W-1:0]  rd_idx;
  logic [2:0]        rd_view;
  logic              rd_sext;
  logic [DATA_W-1:0] rd_data;
  logic              rd_illegal;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [2:0]        wr_view;
  logic [DATA_W-1:0] wr_data;
  logic              wr_illegal;

  always #2.5 clk = ~clk;

  subreg_file #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .NUM_HI   (NUM_HI)
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .rd_idx     (rd_idx),
    .rd_view    (rd_view),
    .rd_sext    (rd_sext),
    .rd_data    (rd_data),
    .rd_illegal (rd_illegal),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_view    (wr_view),
    .wr_data    (wr_data),
    .wr_illegal (wr_illegal)
  );

  logic [DATA_W-1:0] model [NUM_REGS];
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  function automatic bit f_legal(logic [3:0] idx, logic [2:0] view);
    return (view <= 3'd4) && !(view == 3'd4 && idx >= 4'(NUM_HI));
  endfunction

  function automatic logic [63:0] f_read(logic [63:0] v, logic [3:0] idx,
                                         logic [2:0] view, logic sx);
    if (!f_legal(idx, view)) return 64'd0;
    case (view)
      3'd0:    return v;
      3'd1:    return sx ? {{32{v[31]}}, v[31:0]} : {32'd0, v[31:0]};
      3'd2:    return sx ? {{48{v[15]}}, v[15:0]} : {48'd0, v[15:0]};
      3'd3:    return sx ? {{56{v[7]}}, v[7:0]}   : {56'd0, v[7:0]};
      default: return sx ? {{56{v[15]}}, v[15:8]} : {56'd0, v[15:8]};
    endcase
  endfunction

  function automatic logic [63:0] f_merge(logic [63:0] o, logic [2:0] view,
                                          logic [63:0] d);
    case (view)
      3'd0:    return d;
      3'd1:    return {32'd0, d[31:0]};
      3'd2:    return {o[63:16], d[15:0]};
      3'd3:    return {o[63:8], d[7:0]};
      default: return {o[63:16], d[7:0], o[7:0]};
    endcase
  endfunction

  function automatic string f_tag(logic [3:0] idx, logic [2:0] view, logic sx);
    if (!f_legal(idx, view)) return "R7";
    if (view == 3'd0) return "R2";
    if (view == 3'd4) return "R6";
    if (sx) return "R9";
    return "R8";
  endfunction

  task automatic check_val(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare before the rising edge,
  // then update the model with the committed write.
  task automatic cycle(bit we, logic [3:0] widx, logic [2:0] wv,
                       logic [63:0] wd, logic [3:0] ridx, logic [2:0] rv,
                       bit rs, string tag);
    wr_en   = we;
    wr_idx  = widx;
    wr_view = wv;
    wr_data = wd;
    rd_idx  = ridx;
    rd_view = rv;
    rd_sext = rs;
    #1;
    check_val(tag, rd_data, f_read(model[ridx], ridx, rv, rs));
    check_val({tag, " rd_illegal"}, 64'(rd_illegal), 64'(!f_legal(ridx, rv)));
    check_val({tag, " wr_illegal"}, 64'(wr_illegal),
              64'(we && !f_legal(widx, wv)));
    @(posedge clk);
    if (we && f_legal(widx, wv)) model[widx] = f_merge(model[widx], wv, wd);
    @(negedge clk);
  endtask

  task automatic rd(logic [3:0] ridx, logic [2:0] rv, bit rs, string tag);
    cycle(1'b0, 4'd0, 3'd0, 64'd0, ridx, rv, rs, tag);
  endtask

  task automatic wr(logic [3:0] widx, logic [2:0] wv, logic [63:0] wd,
                    string tag);
    cycle(1'b1, widx, wv, wd, 4'd0, 3'd0, 1'b0, tag);
  endtask

  task automatic do_reset();
    rst   = 1'b1;
    wr_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_view = '0; wr_data = '0;
    rd_idx = '0; rd_view = '0; rd_sext = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: every register reads zero after reset
    for (int i = 0; i < NUM_REGS; i++) rd(4'(i), 3'd0, 1'b0, "R1");

    // R2 and R11: full write to register 15
    wr(4'd15, 3'd0, 64'h0123_4567_89AB_CDEF, "R2");
    rd(4'd15, 3'd0, 1'b0, "R2");
    // R3: 32-bit write clears the upper half
    wr(4'd15, 3'd1, 64'hFFFF_FFFF_8000_0001, "R3");
    rd(4'd15, 3'd0, 1'b0, "R3");
    rd(4'd15, 3'd1, 1'b1, "R9");
    // R4: 16-bit write keeps upper bits
    wr(4'd2, 3'd0, 64'hAAAA_AAAA_AAAA_AAAA, "R2");
    wr(4'd2, 3'd2, 64'hFFFF_FFFF_FFFF_1234, "R4");
    rd(4'd2, 3'd0, 1'b0, "R4");
    // R5: byte write keeps upper bits on an extended register
    wr(4'd9, 3'd0, 64'h5555_5555_5555_5555, "R2");
    wr(4'd9, 3'd3, 64'h0000_0000_0000_00C3, "R5");
    rd(4'd9, 3'd0, 1'b0, "R5");
    rd(4'd9, 3'd3, 1'b1, "R9");
    rd(4'd9, 3'd3, 1'b0, "R8");
    // R6: bits 15:8 view on register 1
    wr(4'd1, 3'd0, 64'h1111_2222_3333_4444, "R2");
    wr(4'd1, 3'd4, 64'h0000_0000_0000_009E, "R6");
    rd(4'd1, 3'd0, 1'b0, "R6");
    rd(4'd1, 3'd4, 1'b1, "R6");
    rd(4'd3, 3'd4, 1'b0, "R6");
    // R7: bits 15:8 view on register 4 and above, undefined codes
    wr(4'd5, 3'd0, 64'hDEAD_BEEF_CAFE_F00D, "R2");
    wr(4'd5, 3'd4, 64'h0000_0000_0000_0077, "R7");
    rd(4'd5, 3'd0, 1'b0, "R7");
    wr(4'd5, 3'd6, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    rd(4'd5, 3'd0, 1'b0, "R7");
    rd(4'd12, 3'd4, 1'b0, "R7");
    rd(4'd4, 3'd4, 1'b1, "R7");
    rd(4'd0, 3'd7, 1'b0, "R7");
    // R10: read and write of the same register in one cycle
    cycle(1'b1, 4'd4, 3'd0, 64'h7777_8888_9999_AAAA, 4'd4, 3'd0, 1'b0, "R10");
    rd(4'd4, 3'd0, 1'b0, "R10");
    // R11: neighbours untouched
    wr(4'd6, 3'd0, 64'h0606_0606_0606_0606, "R2");
    wr(4'd8, 3'd0, 64'h0808_0808_0808_0808, "R2");
    wr(4'd7, 3'd0, 64'hFFFF_0000_FFFF_0000, "R11");
    rd(4'd6, 3'd0, 1'b0, "R11");
    rd(4'd8, 3'd0, 1'b0, "R11");
    // R12: no request, no change
    cycle(1'b0, 4'd7, 3'd0, 64'h1234_1234_1234_1234, 4'd7, 3'd0, 1'b0, "R12");
    rd(4'd7, 3'd0, 1'b0, "R12");
    // R8 and R9: extension on the 16-bit view
    rd(4'd7, 3'd2, 1'b0, "R8");
    rd(4'd7, 3'd2, 1'b1, "R9");
    rd(4'd7, 3'd0, 1'b1, "R9");

    // Random traffic, tag chosen from the read view
    for (int n = 0; n < 4000; n++) begin
      logic [3:0]  widx = 4'($urandom);
      logic [3:0]  ridx = ($urandom % 4 == 0) ? widx : 4'($urandom);
      logic [2:0]  wv   = 3'($urandom);
      logic [2:0]  rv   = 3'($urandom);
      bit          rs   = 1'($urandom);
      bit          we   = ($urandom % 4 != 0);
      logic [63:0] wd   = {32'($urandom), 32'($urandom)};
      string       tg   = (we && ridx == widx) ? "R10" : f_tag(ridx, rv, rs);
      if (!we) tg = "R12";
      cycle(we, widx, wv, wd, ridx, rv, rs, tg);
    end

    // R1: reset after traffic clears everything
    do_reset();
    for (int i = 0; i < NUM_REGS; i++) rd(4'(i), 3'd0, 1'b0, "R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule